// File: doc/BRIEF.md
# Three-Bit XOR-Feedback Sequence Generator

This block is a small clocked state machine holding three registered bits, with bit 2 as the most significant and bit 0 as the least significant. On each enabled clock edge it moves through a fixed seven-state cycle. An XOR of the two upper bits feeds the low bit, and the other two bits shift upward. Starting from state 1, the cycle runs 1, 2, 5, 3, 7, 6, 4 and then returns to 1.

State zero maps to itself under the feedback equations, so it is a lock-up point. The block raises a flag while the state is zero. On the next enabled edge it forces the state back to 1.

A seed can be loaded at any time with a strobe, which gives software or a neighbouring block a chosen starting point in the cycle. A synchronous reset returns the state to 1.

Top module: `xorseq3_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state after that edge is 3'b001 and `stuck_zero` is low.
- R2: With `rst` and `seed_ld` low, `cnt_en` high and a nonzero state, the next state is formed as follows: new bit 0 is old bit 2 XOR old bit 1, new bit 1 is old bit 0, and new bit 2 is old bit 1.
- R3: From state 1, seven successive enabled edges give the decimal states 2, 5, 3, 7, 6, 4, 1, read with bit 2 as the MSB.
- R4: With `rst`, `seed_ld` and `cnt_en` all low, the state keeps its value across the edge.
- R5: With `rst` low and `seed_ld` high, the state after the edge equals `seed_val`, whatever the value of `cnt_en`.
- R6: Reset takes priority over a seed load in the same cycle.
- R7: `stuck_zero` is high exactly when `state_q` is 3'b000.
- R8: A zero seed is accepted. From state 000, the next enabled edge that has no load or reset sets the state to 3'b001.
- R9: From any nonzero seed, the state equals that seed again after exactly seven enabled edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to state 1 |
| cnt_en | input | 1 | Advance the sequence on this edge |
| seed_ld | input | 1 | Load `seed_val` on this edge |
| seed_val | input | 3 | Seed value to load |
| state_q | output | 3 | Present state, bit 2 is the MSB |
| stuck_zero | output | 1 | High while the state is zero |

## Verification
The bound checker watches the per-edge rules on every cycle: the return to 1 after reset, holding while disabled, the load value and its priority, the single-step feedback mapping, the recovery from zero, and the zero flag. The full seven-state order and the return to each seed after seven steps span many edges, so only the bench's scenarios show them. The bench walks the order from reset against a fixed list of states and sweeps all seven nonzero seeds.

// File: rtl/xorseq3_pkg.sv
package xorseq3_pkg;
   localparam int STATE_W = 3;
   typedef logic [STATE_W-1:0] seq_state_t;

   // One step of the feedback map: upper bits shift up, low bit takes the XOR.
   function automatic seq_state_t feedback_step(input seq_state_t cur);
      seq_state_t nxt;
      nxt[2] = cur[1];
      nxt[1] = cur[0];
      nxt[0] = cur[2] ^ cur[1];
      return nxt;
   endfunction
endpackage

// File: rtl/xorseq3_next.sv
module xorseq3_next
   import xorseq3_pkg::*;
#(
   parameter bit         ZERO_RECOVERY = 1'b1,
   parameter seq_state_t RECOVER_STATE = 3'b001
) (
   input  seq_state_t cur_state,
   output seq_state_t nxt_state,
   output logic       is_zero
);
   seq_state_t stepped;

   always_comb begin
      stepped = feedback_step(cur_state);
      is_zero = (cur_state == '0);
   end

   generate
      if (ZERO_RECOVERY) begin : g_recover
         always_comb nxt_state = is_zero ? RECOVER_STATE : stepped;
      end else begin : g_plain
         always_comb nxt_state = stepped;
      end
   endgenerate
endmodule

// File: rtl/xorseq3_state_reg.sv
module xorseq3_state_reg
   import xorseq3_pkg::*;
#(
   parameter seq_state_t INIT_STATE = 3'b001
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       load,
   input  logic       step,
   input  seq_state_t load_val,
   input  seq_state_t step_val,
   output seq_state_t q
);
   // Priority: reset, then load, then step, else hold.
   always_ff @(posedge clk) begin
      if (rst)       q <= INIT_STATE;
      else if (load) q <= load_val;
      else if (step) q <= step_val;
   end
endmodule

// File: rtl/xorseq3_gen.sv
module xorseq3_gen
   import xorseq3_pkg::*;
#(
   parameter logic [2:0] RESET_STATE   = 3'b001,
   parameter bit         ZERO_RECOVERY = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cnt_en,
   input  logic       seed_ld,
   input  logic [2:0] seed_val,
   output logic [2:0] state_q,
   output logic       stuck_zero
);
   localparam seq_state_t RECOVER_STATE = seq_state_t'(RESET_STATE);

   generate
      if (RESET_STATE == 3'b000) begin : g_bad_reset
         $error("RESET_STATE must be nonzero: zero is the lock-up point");
      end
      if (STATE_W != 3) begin : g_bad_width
         $error("Feedback map is defined for a three-bit state only");
      end
   endgenerate

   seq_state_t cur_s;
   seq_state_t nxt_s;
   logic       zero_s;

   xorseq3_next #(
      .ZERO_RECOVERY(ZERO_RECOVERY),
      .RECOVER_STATE(RECOVER_STATE)
   ) next_i (
      .cur_state(cur_s),
      .nxt_state(nxt_s),
      .is_zero  (zero_s)
   );

   xorseq3_state_reg #(
      .INIT_STATE(RECOVER_STATE)
   ) reg_i (
      .clk     (clk),
      .rst     (rst),
      .load    (seed_ld),
      .step    (cnt_en),
      .load_val(seq_state_t'(seed_val)),
      .step_val(nxt_s),
      .q       (cur_s)
   );

   assign state_q    = cur_s;
   assign stuck_zero = zero_s;
endmodule

// File: rtl/xorseq3_gen_chk.sv
module xorseq3_gen_chk (
   input logic       clk,
   input logic       rst,
   input logic       cnt_en,
   input logic       seed_ld,
   input logic [2:0] seed_val,
   input logic [2:0] state_q,
   input logic       stuck_zero
);
   AST_RESET_TO_ONE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (state_q == 3'b001 && !stuck_zero)); // R1 R6
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!seed_ld && !cnt_en) |=> $stable(state_q)); // R4
   AST_LOAD_SEED: assert property (@(posedge clk) disable iff (rst)
      seed_ld |=> (state_q == $past(seed_val))); // R5
   AST_FEEDBACK_STEP: assert property (@(posedge clk) disable iff (rst)
      (!seed_ld && cnt_en && state_q != 3'b000) |=>
      (state_q[2] == $past(state_q[1]) && state_q[1] == $past(state_q[0])
       && state_q[0] == ($past(state_q[2]) ^ $past(state_q[1])))); // R2
   AST_ZERO_RECOVER: assert property (@(posedge clk) disable iff (rst)
      (!seed_ld && cnt_en && stuck_zero) |=> (state_q == 3'b001)); // R8
   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
      stuck_zero == (state_q == 3'b000)); // R7
endmodule

bind xorseq3_gen xorseq3_gen_chk chk_i (.*);

// File: tb/xorseq3_gen_tb_top.sv
module xorseq3_gen_tb_top;
   typedef struct {
      logic [2:0] exp_state;
      logic       exp_flag;
      string      req;
   } exp_item_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cnt_en = 1'b0;
   logic       seed_ld = 1'b0;
   logic [2:0] seed_val = 3'b000;
   logic [2:0] state_q;
   logic       stuck_zero;

   exp_item_t  sb_q[$];
   logic [2:0] model = 3'b001;
   int         n_checks = 0;
   int         n_errors = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   xorseq3_gen dut_i (
      .clk(clk), .rst(rst), .cnt_en(cnt_en), .seed_ld(seed_ld),
      .seed_val(seed_val), .state_q(state_q), .stuck_zero(stuck_zero)
   );

   // Reference model built from the requirement text.
   function automatic logic [2:0] ref_next(input logic r, input logic l,
                                           input logic e, input logic [2:0] s,
                                           input logic [2:0] cur);
      if (r) return 3'd1;
      if (l) return s;
      if (!e) return cur;
      if (cur == 3'd0) return 3'd1;
      return {cur[1], cur[0], cur[2] ^ cur[1]};
   endfunction

   task automatic drive_exp(input logic r, input logic l, input logic e,
                            input logic [2:0] s, input logic [2:0] exp_s,
                            input string req);
      exp_item_t it;
      @(negedge clk);
      rst = r; seed_ld = l; cnt_en = e; seed_val = s;
      model = exp_s;
      it.exp_state = exp_s;
      it.exp_flag  = (exp_s == 3'd0);
      it.req       = req;
      sb_q.push_back(it);
   endtask

   task automatic drive_op(input logic r, input logic l, input logic e,
                           input logic [2:0] s, input string req);
      drive_exp(r, l, e, s, ref_next(r, l, e, s, model), req);
   endtask

   // Monitor: compares each result well after the edge that produced it.
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (state_q !== it.exp_state || stuck_zero !== it.exp_flag) begin
               n_errors++;
               $display("FAIL %s: state=%0d flag=%0b expected state=%0d flag=%0b",
                        it.req, state_q, stuck_zero, it.exp_state, it.exp_flag);
            end
         end
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      logic [2:0] r3_order[7] = '{3'd2, 3'd5, 3'd3, 3'd7, 3'd6, 3'd4, 3'd1};
      // R1: reset state
      drive_op(1, 0, 0, 3'd0, "R1 reset");
      drive_op(1, 0, 1, 3'd0, "R1 reset with enable");
      // R3: order from state 1 against a fixed list
      for (int i = 0; i < 7; i++) drive_exp(0, 0, 1, 3'd0, r3_order[i], "R3 order");
      // R4: hold while idle
      drive_op(0, 0, 1, 3'd0, "R2 step");
      drive_op(0, 0, 0, 3'd6, "R4 hold");
      drive_op(0, 0, 0, 3'd6, "R4 hold");
      // R5: load wins over enable
      drive_exp(0, 1, 1, 3'd6, 3'd6, "R5 load with enable");
      drive_exp(0, 1, 0, 3'd3, 3'd3, "R5 load idle");
      drive_op(0, 0, 1, 3'd0, "R2 step after load");
      // R6: reset wins over load
      drive_exp(1, 1, 1, 3'd7, 3'd1, "R6 reset over load");
      // R7 / R8: zero seed, flag, hold in zero, then recovery
      drive_exp(0, 1, 0, 3'd0, 3'd0, "R7 zero flag after zero seed");
      drive_exp(0, 0, 0, 3'd0, 3'd0, "R8 zero holds when disabled");
      drive_exp(0, 0, 1, 3'd0, 3'd1, "R8 recovery to one");
      drive_exp(0, 0, 1, 3'd0, 3'd2, "R7 flag low again");
      // R9: every nonzero seed returns after seven steps
      for (int sd = 1; sd < 8; sd++) begin
         drive_exp(0, 1, 0, 3'(sd), 3'(sd), "R9 seed load");
         for (int k = 0; k < 6; k++) drive_op(0, 0, 1, 3'd0, "R2 step in sweep");
         drive_exp(0, 0, 1, 3'd0, 3'(sd), "R9 return to seed");
      end
      drive_op(0, 0, 0, 3'd0, "R4 final hold");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule